// File: doc/BRIEF.md
# Multithreaded In-Order Issue Selector

This block decides, every clock cycle, which of six hardware threads sends instructions to execution and how many of that thread's queued instructions leave as one group. Each thread has its own in-order queue. The block sees the queue head as a window of up to four entries plus a count of how many of those entries are valid. Each entry holds a compiler-set parallel flag, a predicate register index and an opaque payload. Thread choice and group formation are combinational from the inputs. The arbitration state (round-robin pointer, alternating phase) and a running total of issued instructions are registered.

A policy input selects how threads compete. Round-robin serves threads in rotating order. Fixed priority always favours the lowest-numbered thread. The alternating policy gives top priority to the lowest and to the highest thread number on successive cycles. Under every policy a thread with an empty queue is passed over in the same cycle. A slot is therefore lost only when every queue is empty. Instructions whose predicate reads false still leave the queue and count as issued, but their execute-enable is low.

Top module: `issue_sel_top`

## Requirements
- R1: Entry layout is bit 0 = parallel flag, bits 3:1 = predicate index, bits 11:4 = payload. A group takes head entries in order and closes on the first entry whose flag is 1, which is included; entries with flag 0 keep the group open.
- R2: A group never exceeds 4 entries or the thread's valid count (0 to 4); if neither a flag of 1 nor the cap ends it, all valid entries go.
- R3: Lane k's execute-enable equals bit (thread*8 + predicate index) of the predicate file when the lane is valid and is 0 otherwise; a squashed lane is still counted in issueCount and in the dequeue count.
- R4: With policySel = 0 (round-robin), the search starts at the pointer and wraps upward; after any issue the pointer becomes the winner plus one, modulo 6.
- R5: A thread with a valid count of 0 is never chosen and the next eligible thread wins in the same cycle; with no eligible thread, issueValid, issueCount, issueThread and all lanes are 0 and the pointer holds.
- R6: With policySel = 1, the lowest-numbered eligible thread wins.
- R7: With policySel = 2, the search order is ascending from thread 0 when the phase is 0 and descending from thread 5 when it is 1; the phase is 0 after reset and toggles on every clock edge out of reset.
- R8: deqCount holds a 3-bit field per thread (thread t at bits 3t+2:3t). It equals issueCount for the winning thread and 0 for every other thread.
- R9: issuedTotal increases on each clock edge by the issueCount of the cycle before.
- R10: Reset clears issuedTotal, the round-robin pointer and the alternating phase.
- R11: Lane k is valid exactly for k below issueCount and carries the payload of head entry k of the winner in bits 8k+7:8k; invalid lanes carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policySel | input | 2 | 0 round-robin, 1 fixed priority, 2 alternating |
| headCount | input | 18 | Valid head entries per thread, 3 bits each |
| headEntries | input | 288 | Four 12-bit head entries per thread, entry k of thread t at (4t+k)*12 |
| predFile | input | 48 | Predicate registers, 8 per thread |
| issueValid | output | 1 | A group issues this cycle |
| issueThread | output | 3 | Winning thread |
| issueCount | output | 3 | Group size |
| laneValid | output | 4 | Occupied lanes |
| laneExec | output | 4 | Execute-enable per lane |
| lanePayload | output | 32 | Payload per lane |
| deqCount | output | 18 | Entries removed per thread |
| issuedTotal | output | 32 | Running count of issued instructions |

## Verification
The assertions assume that headCount never exceeds 4 for any thread and that policySel stays within the three defined codes. The bench draws valid counts from 0 to 4 only and uses policy codes 0, 1 and 2. The stimulus sweeps all 64 eligibility masks under each policy and every flag pattern at every valid count. This covers the skip, wrap and cap cases without going outside those assumptions.

// File: rtl/issue_sel_pkg.sv
package issue_sel_pkg;
  localparam int THREADS   = 6;
  localparam int SLOTS     = 4;
  localparam int PREDS     = 8;
  localparam int PAYLOAD_W = 8;
  localparam int TOTAL_W   = 32;
  localparam int TID_W     = $clog2(THREADS);
  localparam int CNT_W     = $clog2(SLOTS + 1);
  localparam int PIDX_W    = $clog2(PREDS);
  localparam int ENTRY_W   = PAYLOAD_W + PIDX_W + 1;

  typedef enum logic [1:0] {
    POL_ROUND     = 2'd0,
    POL_FIXED     = 2'd1,
    POL_ALTERNATE = 2'd2
  } policy_e;

  typedef struct packed {
    logic [PAYLOAD_W-1:0] payload;
    logic [PIDX_W-1:0]    predIdx;
    logic                 parFlag;
  } entry_t;

  typedef struct packed {
    logic             issueEn;
    logic [TID_W-1:0] winner;
  } strobe_t;
endpackage

// File: rtl/issue_sel_ctrl.sv
module issue_sel_ctrl
  import issue_sel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         policySel,
  input  logic [THREADS-1:0] eligible,
  output strobe_t            strobe
);
  logic [TID_W-1:0] rrPtr;
  logic             altPhase;

  // Walk the candidate order of the active policy; first eligible thread wins.
  always_comb begin
    int cand;
    strobe = '0;
    for (int i = 0; i < THREADS; i++) begin
      case (policySel)
        POL_FIXED:     cand = i;
        POL_ALTERNATE: cand = altPhase ? (THREADS - 1 - i) : i;
        default: begin
          cand = int'(rrPtr) + i;
          if (cand >= THREADS) cand = cand - THREADS;
        end
      endcase
      if (!strobe.issueEn && eligible[TID_W'(cand)]) begin
        strobe.issueEn = 1'b1;
        strobe.winner  = TID_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrPtr    <= '0;
      altPhase <= 1'b0;
    end else begin
      altPhase <= ~altPhase;
      if (strobe.issueEn)
        rrPtr <= (strobe.winner == TID_W'(THREADS - 1)) ? '0 : strobe.winner + 1'b1;
    end
  end
endmodule

// File: rtl/issue_sel_datapath.sv
module issue_sel_datapath
  import issue_sel_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  strobe_t                            strobe,
  input  logic [THREADS*CNT_W-1:0]           headCount,
  input  logic [THREADS*SLOTS*ENTRY_W-1:0]   headEntries,
  input  logic [THREADS*PREDS-1:0]           predFile,
  output logic                               issueValid,
  output logic [TID_W-1:0]                   issueThread,
  output logic [CNT_W-1:0]                   issueCount,
  output logic [SLOTS-1:0]                   laneValid,
  output logic [SLOTS-1:0]                   laneExec,
  output logic [SLOTS*PAYLOAD_W-1:0]         lanePayload,
  output logic [THREADS*CNT_W-1:0]           deqCount,
  output logic [TOTAL_W-1:0]                 issuedTotal
);
  logic [THREADS*CNT_W-1:0] grpLenAll;
  logic [CNT_W-1:0]         winLen;

  // Group length of every thread, formed from its head window.
  for (genvar t = 0; t < THREADS; t++) begin : g_thread
    logic [CNT_W-1:0] len;
    always_comb begin
      logic   stop;
      entry_t e;
      len  = '0;
      stop = 1'b0;
      for (int k = 0; k < SLOTS; k++) begin
        e = entry_t'(headEntries[(t*SLOTS+k)*ENTRY_W +: ENTRY_W]);
        if (!stop && (CNT_W'(k) < headCount[t*CNT_W +: CNT_W])) begin
          len  = len + 1'b1;
          stop = e.parFlag;
        end else begin
          stop = 1'b1;
        end
      end
    end
    assign grpLenAll[t*CNT_W +: CNT_W] = len;
  end

  assign winLen      = grpLenAll[int'(strobe.winner)*CNT_W +: CNT_W];
  assign issueValid  = strobe.issueEn;
  assign issueThread = strobe.issueEn ? strobe.winner : '0;
  assign issueCount  = strobe.issueEn ? winLen : '0;

  always_comb begin
    entry_t e;
    for (int k = 0; k < SLOTS; k++) begin
      e = entry_t'(headEntries[(int'(strobe.winner)*SLOTS+k)*ENTRY_W +: ENTRY_W]);
      laneValid[k] = strobe.issueEn && (CNT_W'(k) < winLen);
      laneExec[k]  = laneValid[k] && predFile[int'(strobe.winner)*PREDS + int'(e.predIdx)];
      lanePayload[k*PAYLOAD_W +: PAYLOAD_W] = laneValid[k] ? e.payload : '0;
    end
  end

  always_comb begin
    for (int t = 0; t < THREADS; t++)
      deqCount[t*CNT_W +: CNT_W] =
        (strobe.issueEn && strobe.winner == TID_W'(t)) ? winLen : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) issuedTotal <= '0;
    else        issuedTotal <= issuedTotal + TOTAL_W'(issueCount);
  end
endmodule

// File: rtl/issue_sel_top.sv
module issue_sel_top
  import issue_sel_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [1:0]                       policySel,
  input  logic [THREADS*CNT_W-1:0]         headCount,
  input  logic [THREADS*SLOTS*ENTRY_W-1:0] headEntries,
  input  logic [THREADS*PREDS-1:0]         predFile,
  output logic                             issueValid,
  output logic [TID_W-1:0]                 issueThread,
  output logic [CNT_W-1:0]                 issueCount,
  output logic [SLOTS-1:0]                 laneValid,
  output logic [SLOTS-1:0]                 laneExec,
  output logic [SLOTS*PAYLOAD_W-1:0]       lanePayload,
  output logic [THREADS*CNT_W-1:0]         deqCount,
  output logic [TOTAL_W-1:0]               issuedTotal
);
  logic [THREADS-1:0] eligible;
  strobe_t            strobe;

  for (genvar t = 0; t < THREADS; t++) begin : g_elig
    assign eligible[t] = |headCount[t*CNT_W +: CNT_W];
  end

  issue_sel_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .policySel(policySel),
    .eligible(eligible), .strobe(strobe)
  );

  issue_sel_datapath i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .headCount(headCount), .headEntries(headEntries), .predFile(predFile),
    .issueValid(issueValid), .issueThread(issueThread), .issueCount(issueCount),
    .laneValid(laneValid), .laneExec(laneExec), .lanePayload(lanePayload),
    .deqCount(deqCount), .issuedTotal(issuedTotal)
  );
endmodule

// File: rtl/issue_sel_checker.sv
module issue_sel_checker
  import issue_sel_pkg::*;
(
  input logic                             clk,
  input logic                             rst_n,
  input logic [1:0]                       policySel,
  input logic [THREADS*CNT_W-1:0]         headCount,
  input logic                             issueValid,
  input logic [TID_W-1:0]                 issueThread,
  input logic [CNT_W-1:0]                 issueCount,
  input logic [SLOTS-1:0]                 laneValid,
  input logic [SLOTS-1:0]                 laneExec,
  input logic [THREADS*CNT_W-1:0]         deqCount,
  input logic [TOTAL_W-1:0]               issuedTotal
);
  logic [CNT_W-1:0] winnerCnt;
  logic             anyReady;
  logic             thread0Ready;
  int               deqSum;

  always_comb begin
    winnerCnt    = headCount[int'(issueThread)*CNT_W +: CNT_W];
    thread0Ready = |headCount[CNT_W-1:0];
    anyReady     = 1'b0;
    deqSum       = 0;
    for (int t = 0; t < THREADS; t++) begin
      anyReady = anyReady | (|headCount[t*CNT_W +: CNT_W]);
      deqSum   = deqSum + int'(deqCount[t*CNT_W +: CNT_W]);
    end
  end

  AST_WINNER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    issueValid |-> winnerCnt != '0); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !anyReady |-> (!issueValid && issueCount == '0 && laneValid == '0)); // R5
  AST_GROUP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    issueValid |-> (issueCount != '0 && issueCount <= winnerCnt && int'(issueCount) <= SLOTS)); // R2
  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(laneValid) == int'(issueCount)); // R11
  AST_EXEC_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (laneExec & ~laneValid) == '0); // R3
  AST_DEQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    deqSum == int'(issueCount)); // R8
  AST_FIXED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (policySel == 2'd1 && thread0Ready) |-> issueThread == '0); // R6
  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> issuedTotal == $past(issuedTotal) + TOTAL_W'($past(issueCount))); // R9
endmodule

bind issue_sel_top issue_sel_checker u_chk (
  .clk(clk), .rst_n(rst_n), .policySel(policySel), .headCount(headCount),
  .issueValid(issueValid), .issueThread(issueThread), .issueCount(issueCount),
  .laneValid(laneValid), .laneExec(laneExec), .deqCount(deqCount),
  .issuedTotal(issuedTotal)
);

// File: tb/test_issue_sel_top.sv
module test_issue_sel_top;
  import issue_sel_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic                             clk = 1'b0;
  logic                             rst_n = 1'b0;
  logic [1:0]                       policySel = '0;
  logic [THREADS*CNT_W-1:0]         headCount = '0;
  logic [THREADS*SLOTS*ENTRY_W-1:0] headEntries = '0;
  logic [THREADS*PREDS-1:0]         predFile = '0;
  logic                             issueValid;
  logic [TID_W-1:0]                 issueThread;
  logic [CNT_W-1:0]                 issueCount;
  logic [SLOTS-1:0]                 laneValid, laneExec;
  logic [SLOTS*PAYLOAD_W-1:0]       lanePayload;
  logic [THREADS*CNT_W-1:0]         deqCount;
  logic [TOTAL_W-1:0]               issuedTotal;

  issue_sel_top i_issue_sel_top (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;

  // Stimulus arrays and reference state
  int     cntA [THREADS];
  entry_t entA [THREADS][SLOTS];
  logic [PREDS-1:0] predA [THREADS];
  int     mPtr = 0;
  int     mPhase = 0;
  longint mTotal = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Called just after a falling edge; leaves just after the next falling edge.
  task automatic step(input int pol);
    int win, len, cand;
    logic [SLOTS-1:0] eValid, eExec;
    logic [SLOTS*PAYLOAD_W-1:0] ePay;
    logic [THREADS*CNT_W-1:0] eDeq;
    string ptag;
    chk(issuedTotal == TOTAL_W'(mTotal), "R9", "issuedTotal", issuedTotal, mTotal);
    policySel = 2'(pol);
    for (int t = 0; t < THREADS; t++) begin
      headCount[t*CNT_W +: CNT_W] = CNT_W'(cntA[t]);
      predFile[t*PREDS +: PREDS] = predA[t];
      for (int k = 0; k < SLOTS; k++)
        headEntries[(t*SLOTS+k)*ENTRY_W +: ENTRY_W] = entA[t][k];
    end
    #1;
    win = -1;
    for (int i = 0; i < THREADS; i++) begin
      if (pol == 1)      cand = i;
      else if (pol == 2) cand = (mPhase != 0) ? THREADS - 1 - i : i;
      else               cand = (mPtr + i) % THREADS;
      if (win < 0 && cntA[cand] != 0) win = cand;
    end
    len = 0; eValid = '0; eExec = '0; ePay = '0; eDeq = '0;
    if (win >= 0) begin
      for (int k = 0; k < SLOTS; k++) begin
        if (k < cntA[win]) begin
          len++;
          eValid[k] = 1'b1;
          eExec[k]  = predA[win][entA[win][k].predIdx];
          ePay[k*PAYLOAD_W +: PAYLOAD_W] = entA[win][k].payload;
          if (entA[win][k].parFlag) break;
        end
      end
      eDeq[win*CNT_W +: CNT_W] = CNT_W'(len);
    end
    ptag = (pol == 1) ? "R6" : (pol == 2) ? "R7" : "R4";
    chk(issueValid == (win >= 0), "R5", "issueValid", issueValid, win >= 0);
    if (win >= 0)
      chk(int'(issueThread) == win, ptag, "issueThread", issueThread, win);
    else
      chk(issueThread == '0, "R5", "idle issueThread", issueThread, 0);
    chk(int'(issueCount) == len, "R1,R2", "issueCount", issueCount, len);
    chk(laneValid == eValid, "R11", "laneValid", laneValid, eValid);
    chk(lanePayload == ePay, "R11", "lanePayload", lanePayload, ePay);
    chk(laneExec == eExec, "R3", "laneExec", laneExec, eExec);
    chk(deqCount == eDeq, "R8", "deqCount", deqCount, eDeq);
    @(posedge clk);
    if (win >= 0) mPtr = (win + 1) % THREADS;
    mPhase = 1 - mPhase;
    mTotal = mTotal + len;
    @(negedge clk);
  endtask

  task automatic randomFill(input int mask);
    for (int t = 0; t < THREADS; t++) begin
      cntA[t] = mask[t] ? 1 + ($urandom % SLOTS) : 0;
      predA[t] = PREDS'($urandom);
      for (int k = 0; k < SLOTS; k++)
        entA[t][k] = entry_t'(ENTRY_W'($urandom));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    for (int t = 0; t < THREADS; t++) begin
      cntA[t] = 0; predA[t] = '0;
      for (int k = 0; k < SLOTS; k++) entA[t][k] = '0;
    end
    repeat (3) @(negedge clk);
    // R10: reset state with all queues empty
    chk(issuedTotal == '0, "R10", "reset issuedTotal", issuedTotal, 0);
    chk(issueValid == 1'b0, "R10", "reset issueValid", issueValid, 0);
    rst_n = 1'b1;

    // R10: after reset, round-robin pointer starts at 0 and phase at 0
    randomFill(6'h3f);
    step(0);
    randomFill(6'h3f);
    step(2);

    // R1, R2: every flag pattern at every valid count on one thread
    for (int c = 0; c <= SLOTS; c++) begin
      for (int f = 0; f < 16; f++) begin
        randomFill(0);
        cntA[0] = c;
        predA[0] = '1;
        for (int k = 0; k < SLOTS; k++) entA[0][k].parFlag = f[k];
        step(1);
      end
    end

    // R3: every predicate file pattern for a full group on thread 2
    for (int p = 0; p < 256; p++) begin
      randomFill(0);
      cntA[2] = SLOTS;
      predA[2] = PREDS'(p);
      for (int k = 0; k < SLOTS; k++) begin
        entA[2][k].parFlag = 1'b0;
        entA[2][k].predIdx = PIDX_W'((k * 2 + (p >> 6)) % PREDS);
      end
      step(1);
    end

    // R4, R5, R6, R7: all eligibility masks under each policy
    for (int pol = 0; pol < 3; pol++) begin
      for (int rep = 0; rep < 2; rep++) begin
        for (int m = 0; m < 64; m++) begin
          randomFill(m);
          step(pol);
        end
      end
    end

    // R4: round-robin wrap with all threads busy
    for (int i = 0; i < 14; i++) begin
      randomFill(6'h3f);
      step(0);
    end

    chk(issuedTotal == TOTAL_W'(mTotal), "R9", "final issuedTotal", issuedTotal, mTotal);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule